// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts the scanlines a picture unit renders and raises an interrupt request to the CPU when that count reaches a target the software programs. A one-cycle line pulse comes in with a flag that says whether rendering is active. Every pulse that arrives while rendering is active advances the count. Every pulse that arrives while rendering is inactive brings the count back to zero and withdraws any pending request. The block does not derive the line pulse from fetch patterns. Another block supplies it.

Software sees two byte registers on the CPU bus. One holds the target line. The other is a control register on write and a status register on read. The status byte reports whether a request is pending and whether the last line pulse fell inside the frame. Reading the status acknowledges the request. The interrupt line is driven only while a request is pending and the control register holds exactly the arming value.

Top module: `scan_irq_top`

## Requirements
- R1: After reset the interrupt line is low, and a status read returns 0x00. The target and control registers both reset to 0.
- R2: A write to address 0x5203 loads the 8-bit target line number.
- R3: A write to address 0x5204 loads the control byte. The interrupt line can be high only while the control byte equals exactly 0x80. Values such as 0x81 or 0xFF keep it low.
- R4: A line pulse while rendering is inactive does three things: the count returns to 0, the pending flag clears and the in-frame flag clears. The interrupt line is therefore low after that edge.
- R5: A line pulse while rendering is active does three things: the count increments, the in-frame flag sets, and the pending flag sets in the same edge that the new count equals the target. The Nth active pulse after a clear fires for target N.
- R6: A read at address 0x5204 returns a status byte in the same cycle: pending in bit 7, in-frame in bit 6, and zero in bits 5..0. The pending flag is then clear from the following edge, so the interrupt line drops.
- R7: A target of 0 never fires. The count saturates at 255 and does not wrap to 0. A target of 255 fires on the 255th active pulse and not on the 254th.
- R8: The interrupt line equals the pending flag AND (control == 0x80). If the control register is armed while a request is already pending, the line rises at the edge that takes that write.
- R9: If a status read and the active line pulse that reaches the target fall in the same cycle, the pending flag stays set. The request is not lost.
- R10: Reads at any other address return 0x00 and leave pending untouched. Writes at any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineTick | input | 1 | One-cycle pulse per scanline |
| renderActive | input | 1 | High while rendering is active |
| cpuAddr | input | 16 | CPU bus address |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdEn | input | 1 | CPU read strobe |
| cpuRdData | output | 8 | CPU read data, valid in the read cycle |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The bench targets the count at its limits. A target of 0 must stay silent over more than 256 active lines, and 255 must fire on exactly the 255th line. A counter that wraps would fire at 0, and an off-by-one compare would fire a line early or late. The bench writes control values that differ from the arming byte by a single bit, and a design that tests only bit 7 would raise the line. It also lines up an acknowledging read with the firing line pulse, where a design that gives the acknowledge priority would drop the request. Finally, it reads the status at a neighbouring address and checks that this neither returns flags nor clears them.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  // Strobes from the control decoder to the datapath, one cycle each.
  typedef struct packed {
    logic loadTarget;   // CPU writes the target line
    logic loadControl;  // CPU writes the control byte
    logic lineReset;    // line pulse outside rendering
    logic lineStep;     // line pulse inside rendering
    logic ackStatus;    // CPU reads the status byte
  } irqStrobes_t;
endpackage

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0] CONTROL_ADDR = 16'h5204
) (
  input  logic              lineTick,
  input  logic              renderActive,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  output irqStrobes_t       strobes,
  output logic              statusSel
);
  logic hitTarget;
  logic hitControl;

  assign hitTarget  = (cpuAddr == TARGET_ADDR);
  assign hitControl = (cpuAddr == CONTROL_ADDR);

  always_comb begin
    strobes             = '0;
    strobes.loadTarget  = cpuWrEn && hitTarget;
    strobes.loadControl = cpuWrEn && hitControl;
    strobes.lineReset   = lineTick && !renderActive;
    strobes.lineStep    = lineTick && renderActive;
    strobes.ackStatus   = cpuRdEn && hitControl;
  end

  assign statusSel = cpuRdEn && hitControl;
endmodule

// File: rtl/scan_irq_dpath.sv
module scan_irq_dpath
  import scan_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 8,
  parameter logic [DATA_W-1:0] ARM_VALUE = 8'h80,
  parameter int PEND_BIT = 7,
  parameter int FRAME_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusByte,
  output logic              irqOut,
  output logic [LINE_W-1:0] lineCount,
  output logic              pendingFlag,
  output logic [LINE_W-1:0] targetVal
);
  localparam logic [LINE_W-1:0] COUNT_MAX = '1;

  logic [DATA_W-1:0] controlReg;
  logic              inFrame;
  logic [LINE_W-1:0] nextCount;
  logic              atMax;
  logic              lineHit;

  assign atMax     = (lineCount == COUNT_MAX);
  assign nextCount = lineCount + 1'b1;
  assign lineHit   = strobes.lineStep && !atMax && (nextCount == targetVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      targetVal  <= '0;
      controlReg <= '0;
    end else begin
      if (strobes.loadTarget)  targetVal  <= wrData[LINE_W-1:0];
      if (strobes.loadControl) controlReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineCount <= '0;
      inFrame   <= 1'b0;
    end else if (strobes.lineReset) begin
      lineCount <= '0;
      inFrame   <= 1'b0;
    end else if (strobes.lineStep) begin
      if (!atMax) lineCount <= nextCount;
      inFrame <= 1'b1;
    end
  end

  // A firing line outranks an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                 pendingFlag <= 1'b0;
    else if (strobes.lineReset) pendingFlag <= 1'b0;
    else if (lineHit)           pendingFlag <= 1'b1;
    else if (strobes.ackStatus) pendingFlag <= 1'b0;
  end

  always_comb begin
    statusByte            = '0;
    statusByte[PEND_BIT]  = pendingFlag;
    statusByte[FRAME_BIT] = inFrame;
  end

  assign irqOut = pendingFlag && (controlReg == ARM_VALUE);
endmodule

// File: rtl/scan_irq_top.sv
module scan_irq_top
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lineTick,
  input  logic              renderActive,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              irqOut
);
  irqStrobes_t       strobes;
  logic              statusSel;
  logic [DATA_W-1:0] statusByte;
  logic [LINE_W-1:0] lineCount;
  logic              pendingFlag;
  logic [LINE_W-1:0] targetVal;

  scan_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .lineTick(lineTick), .renderActive(renderActive), .cpuAddr(cpuAddr),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .strobes(strobes), .statusSel(statusSel)
  );

  scan_irq_dpath #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(cpuWrData),
    .statusByte(statusByte), .irqOut(irqOut), .lineCount(lineCount),
    .pendingFlag(pendingFlag), .targetVal(targetVal)
  );

  assign cpuRdData = statusSel ? statusByte : '0;
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lineTick,
  input logic              renderActive,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuRdEn,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              irqOut,
  input logic [LINE_W-1:0] lineCount,
  input logic              pendingFlag,
  input logic [LINE_W-1:0] targetVal
);
  // R4
  off_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && !renderActive) |=> (!irqOut && lineCount == '0 && !pendingFlag));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && renderActive && lineCount != '1) |=> (lineCount == $past(lineCount) + 1'b1));

  // R7
  count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && renderActive && lineCount == '1) |=> (lineCount == '1));

  // R7
  zero_target_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendingFlag) |-> ($past(targetVal) != '0 && lineCount == $past(targetVal)));

  // R6
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuRdEn && cpuAddr == 16'h5204 && !lineTick) |=> !irqOut);

  // R6
  status_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuRdData[5:0] == 6'd0);

  // R8
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> pendingFlag);
endmodule

bind scan_irq_top scan_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lineTick(lineTick), .renderActive(renderActive),
  .cpuAddr(cpuAddr), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData), .irqOut(irqOut),
  .lineCount(lineCount), .pendingFlag(pendingFlag), .targetVal(targetVal)
);

// File: tb/scan_irq_top_test.sv
module scan_irq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lineTick = 1'b0;
  logic        renderActive = 1'b0;
  logic [15:0] cpuAddr = 16'h0;
  logic        cpuWrEn = 1'b0;
  logic [7:0]  cpuWrData = 8'h0;
  logic        cpuRdEn = 1'b0;
  logic [7:0]  cpuRdData;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scan_irq_top uut (
    .clk(clk), .rst_n(rst_n), .lineTick(lineTick), .renderActive(renderActive),
    .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn),
    .cpuRdData(cpuRdData), .irqOut(irqOut)
  );

  localparam logic [15:0] A_TGT = 16'h5203;
  localparam logic [15:0] A_CTL = 16'h5204;

  // Vector: {op[1:0], arg[7:0], expIrq, expStatus[7:0]}
  // op 0 write target, 1 write control, 2 line pulse (arg[0]=active), 3 status read
  localparam int NVEC = 18;
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 8'd3,   1'b0, 8'h00},  // R2 target 3
    {2'd1, 8'h80,  1'b0, 8'h00},  // R3 armed
    {2'd2, 8'd1,   1'b0, 8'h00},  // R5 line 1
    {2'd3, 8'd0,   1'b0, 8'h40},  // R6 in-frame only
    {2'd2, 8'd1,   1'b0, 8'h00},  // R5 line 2
    {2'd2, 8'd1,   1'b1, 8'h00},  // R5 line 3 fires
    {2'd3, 8'd0,   1'b0, 8'hC0},  // R6 ack
    {2'd3, 8'd0,   1'b0, 8'h40},  // R6 cleared
    {2'd2, 8'd1,   1'b0, 8'h00},  // R5 line 4
    {2'd2, 8'd0,   1'b0, 8'h00},  // R4 off frame
    {2'd3, 8'd0,   1'b0, 8'h00},  // R4 flags clear
    {2'd1, 8'h81,  1'b0, 8'h00},  // R3 not exact
    {2'd2, 8'd1,   1'b0, 8'h00},
    {2'd2, 8'd1,   1'b0, 8'h00},
    {2'd2, 8'd1,   1'b0, 8'h00},  // R3 pending but 0x81
    {2'd1, 8'h80,  1'b1, 8'h00},  // R8 late arm
    {2'd2, 8'd0,   1'b1 ^ 1'b1, 8'h00},  // R4 drop
    {2'd3, 8'd0,   1'b0, 8'h00}   // R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic pulse(input logic active);
    @(negedge clk);
    lineTick = 1'b1; renderActive = active;
    @(negedge clk);
    lineTick = 1'b0;
  endtask

  task automatic readReg(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRdEn = 1'b1;
    #1 d = cpuRdData;
    @(negedge clk);
    cpuRdEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    readReg(A_CTL, rd);
    check("R1 status", rd, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic [7:0] arg;
      logic       eIrq;
      logic [7:0] eStat;
      {op, arg, eIrq, eStat} = VEC[i];
      case (op)
        2'd0: writeReg(A_TGT, arg);
        2'd1: writeReg(A_CTL, arg);
        2'd2: pulse(arg[0]);
        default: begin
          readReg(A_CTL, rd);
          check($sformatf("R6 vec%0d status", i), rd, eStat);
        end
      endcase
      check($sformatf("R3/R8 vec%0d irq", i), {7'd0, irqOut}, {7'd0, eIrq});
    end

    // R7 target 0 never fires across saturation
    writeReg(A_TGT, 8'd0);
    pulse(1'b0);
    for (int i = 0; i < 260; i++) pulse(1'b1);
    readReg(A_CTL, rd);
    check("R7 zero target", rd, 8'h40);

    // R7 target 255 fires on the 255th line only
    writeReg(A_TGT, 8'd255);
    pulse(1'b0);
    for (int i = 0; i < 254; i++) pulse(1'b1);
    check("R7 line 254 silent", {7'd0, irqOut}, 8'h00);
    pulse(1'b1);
    check("R7 line 255 fires", {7'd0, irqOut}, 8'h01);
    readReg(A_CTL, rd);
    check("R7 status", rd, 8'hC0);
    pulse(1'b1);
    check("R7 saturated no refire", {7'd0, irqOut}, 8'h00);

    // R9 ack coinciding with the firing line
    writeReg(A_TGT, 8'd2);
    pulse(1'b0);
    pulse(1'b1);
    @(negedge clk);
    cpuAddr = A_CTL; cpuRdEn = 1'b1; lineTick = 1'b1; renderActive = 1'b1;
    @(negedge clk);
    cpuRdEn = 1'b0; lineTick = 1'b0;
    check("R9 pending survives", {7'd0, irqOut}, 8'h01);

    // R10 other address read and write
    readReg(16'h5205, rd);
    check("R10 other read", rd, 8'h00);
    check("R10 pending kept", {7'd0, irqOut}, 8'h01);
    readReg(A_CTL, rd);
    writeReg(16'h5202, 8'd1);
    pulse(1'b0);
    pulse(1'b1);
    check("R10 target unchanged at 1", {7'd0, irqOut}, 8'h00);
    pulse(1'b1);
    check("R10 target still 2", {7'd0, irqOut}, 8'h01);

    // R3 0xFF is not armed
    writeReg(A_CTL, 8'hFF);
    check("R3 0xFF", {7'd0, irqOut}, 8'h00);
    writeReg(A_CTL, 8'h00);
    check("R3 0x00", {7'd0, irqOut}, 8'h00);

    finish();
  end
endmodule